// File: doc/BRIEF.md
# Command-Sequenced I2C Write Master

This block is a bus master that performs one I2C write transaction by stepping through a short list of stored command words. A separate byte buffer supplies the data. The first buffer entry is the address byte: the 7-bit target address in bits 7..1 and a write flag of 0 in bit 0. The payload bytes follow it in the order they are to be sent. A typical command list has three entries: a START, then a WRITE whose count is N+1 (the address byte plus N payload bytes), then a STOP. Software fills both stores, sets a divider and a threshold, and pulses `start`. The block launches the transaction only if the SCL line is seen high at that moment.

The bus pins are open-drain. For each line there is an output that pulls the line low (`*_oe`) and an input that samples it. While the transfer runs, the block checks each acknowledge against the expected value carried in the WRITE command. It also watches for a competing master on SDA. Once the byte count passes a threshold, it flags this and records the buffer index of the last byte sent, so software can refill the buffer behind the transfer. All outcomes are reported as sticky flags.

Top module: `i2c_cmd_writer`

## Requirements
- R1: Each command word has the opcode in bits [1:0] (0 = START, 1 = WRITE, 2 or 3 = STOP), the ACK-check enable in bit 2, the expected ACK level in bit 3 and the byte count in bits [11:4]. A WRITE with count C reads buffer entries in rising index order from index 0, C in total. Each byte goes out MSB first, one bit per SCL pulse, followed by a ninth pulse for the acknowledge.
- R2: A `start` pulse that arrives while `scl_in` is low has no effect. The lines stay released, no flag is set and the request is not remembered.
- R3: A normal transaction produces exactly one START condition (SDA falls while SCL is high) and one STOP condition (SDA rises while SCL is high). During data bits, SDA is stable while SCL is high.
- R4: With ACK checking enabled, an acknowledge level different from the expected field sets the ACK-error flag (bit 1). The block then drives a STOP and does not set the done flag. An acknowledge equal to the expected field, including an expected level of 1, lets the transfer go on.
- R5: With ACK checking disabled, a NACK is ignored and the transaction completes.
- R6: If SDA reads low while the block releases it for a 1 data bit with SCL high, the arbitration-lost flag (bit 2) is set. On the next clock both lines are released, and no STOP is driven.
- R7: When the count of bytes sent in the transaction becomes threshold+1, the threshold flag (bit 3) is set and `last_addr` takes that byte's buffer index. `last_addr` changes only on this event or on completion.
- R8: When the STOP of a successful transaction ends, the done flag (bit 0) is set and `last_addr` takes the index of the last byte sent.
- R9: During data bits, SCL high and low phases each last `half_period` clocks (`half_period` must be at least 2).
- R10: Flags are sticky. Writing 1 to an `irq_clr` bit clears that flag. A flag event in the same cycle wins over the clear. Clearing one bit leaves the others unchanged.
- R11: After reset both lines are released, all flags are 0 and `last_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| start | input | 1 | Launch request, one-cycle pulse |
| half_period | input | HALF_W | SCL half-period in clocks |
| tx_thresh | input | 8 | Byte-count threshold for the refill flag |
| cmd_addr | output | CMD_AW | Command store read index |
| cmd_data | input | 12 | Command word at `cmd_addr` |
| buf_addr | output | BUF_AW | Data buffer read index |
| buf_data | input | 8 | Buffer byte at `buf_addr` |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq_clr | input | 4 | Write-one-to-clear for the flags |
| irq_flags | output | 4 | Sticky flags: 0 done, 1 ACK error, 2 arbitration lost, 3 threshold |
| last_addr | output | BUF_AW | Buffer index of the last reported byte |

## Verification
The bench builds the block with a 4-entry command store, a 16-entry buffer and an 8-bit divider, and runs it at a half-period of 3 clocks. This keeps a full byte under 60 clocks, so several complete transactions fit in a short run. A threshold of 2 puts the refill event in the middle of a six-byte write, so the threshold index and the final index can be seen in `last_addr` one after the other. The small buffer lets the bench choose which byte is NACKed or has a competing master pull SDA low, and check the behaviour on exactly that byte.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_STOP  = 2'd2,
    OP_STOP2 = 2'd3
  } op_e;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic             ack_exp;
    logic             ack_chk;
    op_e              op;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  localparam int FL_DONE = 0;
  localparam int FL_ACK  = 1;
  localparam int FL_ARB  = 2;
  localparam int FL_THR  = 3;
  localparam int FL_N    = 4;

  // acknowledge is bad only when checking is on and the level differs
  function automatic logic ack_mismatch(input logic chk, input logic expect_lvl,
                                        input logic got);
    return chk && (got != expect_lvl);
  endfunction

  // threshold crossed when the running count reaches thresh + 1
  function automatic logic thr_crossed(input logic [CNT_W:0] sent_after,
                                       input logic [CNT_W-1:0] thresh);
    return sent_after == ({1'b0, thresh} + (CNT_W+1)'(1));
  endfunction

  function automatic logic [CNT_W:0] sat_inc(input logic [CNT_W:0] v);
    return (&v) ? v : v + (CNT_W+1)'(1);
  endfunction
endpackage

// File: rtl/i2cw_tick.sv
module i2cw_tick #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_period,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;

  assign tick = run && (({1'b0, cnt} + (HALF_W+1)'(1)) >= {1'b0, half_period});

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + HALF_W'(1);
  end
endmodule

// File: rtl/i2cw_arb.sv
module i2cw_arb (
  input  logic window,
  input  logic drive_bit,
  input  logic scl_in,
  input  logic sda_in,
  output logic lost
);
  // released SDA seen low while the clock is high: another master owns the bit
  assign lost = window && scl_in && drive_bit && !sda_in;
endmodule

// File: rtl/i2cw_irq.sv
module i2cw_irq #(
  parameter int BUF_AW = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ev_done,
  input  logic                       ev_ackerr,
  input  logic                       ev_arb,
  input  logic                       ev_thr,
  input  logic [BUF_AW-1:0]          ev_addr,
  input  logic [i2cw_pkg::FL_N-1:0]  clr,
  output logic [i2cw_pkg::FL_N-1:0]  flags,
  output logic [BUF_AW-1:0]          last_addr
);
  import i2cw_pkg::*;
  logic [FL_N-1:0] ev;

  always_comb begin
    ev          = '0;
    ev[FL_DONE] = ev_done;
    ev[FL_ACK]  = ev_ackerr;
    ev[FL_ARB]  = ev_arb;
    ev[FL_THR]  = ev_thr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags     <= '0;
      last_addr <= '0;
    end else begin
      flags <= (flags & ~clr) | ev;
      if (ev_thr || ev_done) last_addr <= ev_addr;
    end
  end
endmodule

// File: rtl/i2cw_seq.sv
module i2cw_seq #(
  parameter int CMD_AW = 2,
  parameter int BUF_AW = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         tick,
  input  logic                         arb_lost,
  input  logic                         scl_in,
  input  logic                         sda_in,
  input  logic [i2cw_pkg::CNT_W-1:0]   tx_thresh,
  output logic [CMD_AW-1:0]            cmd_addr,
  input  logic [i2cw_pkg::CMD_W-1:0]   cmd_data,
  output logic [BUF_AW-1:0]            buf_addr,
  input  logic [7:0]                   buf_data,
  output logic                         scl_oe,
  output logic                         sda_oe,
  output logic                         run,
  output logic                         arb_window,
  output logic                         drive_bit,
  output logic                         idle,
  output logic                         ev_done,
  output logic                         ev_ackerr,
  output logic                         ev_thr,
  output logic [BUF_AW-1:0]            ev_addr
);
  import i2cw_pkg::*;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_STA0, S_STA1, S_LOAD, S_BLO, S_BHI,
    S_ALO, S_AHI, S_SP0, S_SP1, S_SP2
  } st_e;

  st_e               st;
  cmd_t              cmd;
  logic [CMD_AW-1:0] cmd_idx;
  logic [BUF_AW-1:0] data_ptr, last_ptr;
  logic [7:0]        shreg;
  logic [2:0]        bitn;
  logic [CNT_W-1:0]  left;
  logic              chk_q, exp_q, aborted;
  logic [CNT_W:0]    sent, sent_nx;
  logic              scl_q, sda_q;
  logic              byte_end, ack_bad;

  assign cmd      = cmd_t'(cmd_data);
  assign cmd_addr = cmd_idx;
  assign buf_addr = data_ptr;
  assign scl_oe   = !scl_q;
  assign sda_oe   = !sda_q;
  assign idle     = (st == S_IDLE);
  assign run      = !(st inside {S_IDLE, S_FETCH, S_LOAD});
  assign arb_window = (st == S_BHI) && scl_q;
  assign drive_bit  = sda_q;

  assign sent_nx  = sat_inc(sent);
  assign byte_end = (st == S_AHI) && tick && !arb_lost;
  assign ack_bad  = ack_mismatch(chk_q, exp_q, sda_in);
  assign ev_ackerr = byte_end && ack_bad;
  assign ev_thr    = byte_end && thr_crossed(sent_nx, tx_thresh);
  assign ev_done   = (st == S_SP2) && tick && !aborted && !arb_lost;
  assign ev_addr   = ev_thr ? data_ptr : last_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cmd_idx  <= '0;
      data_ptr <= '0;
      last_ptr <= '0;
      shreg    <= '0;
      bitn     <= '0;
      left     <= '0;
      chk_q    <= 1'b0;
      exp_q    <= 1'b0;
      aborted  <= 1'b0;
      sent     <= '0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else if (arb_lost) begin
      st    <= S_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      case (st)
        S_IDLE: begin
          if (start && scl_in) begin
            st       <= S_FETCH;
            cmd_idx  <= '0;
            data_ptr <= '0;
            sent     <= '0;
            aborted  <= 1'b0;
          end
        end
        S_FETCH: begin
          case (cmd.op)
            OP_START: begin
              scl_q <= 1'b1;
              sda_q <= 1'b1;
              st    <= S_STA0;
            end
            OP_WRITE: begin
              if (cmd.count == '0) begin
                cmd_idx <= cmd_idx + CMD_AW'(1);
              end else begin
                left  <= cmd.count;
                chk_q <= cmd.ack_chk;
                exp_q <= cmd.ack_exp;
                st    <= S_LOAD;
              end
            end
            default: begin
              scl_q <= 1'b0;
              st    <= S_SP0;
            end
          endcase
        end
        S_STA0: if (tick) begin
          sda_q <= 1'b0;
          st    <= S_STA1;
        end
        S_STA1: if (tick) begin
          cmd_idx <= cmd_idx + CMD_AW'(1);
          st      <= S_FETCH;
        end
        S_LOAD: begin
          shreg <= buf_data;
          bitn  <= '0;
          scl_q <= 1'b0;
          st    <= S_BLO;
        end
        S_BLO: begin
          sda_q <= shreg[7];
          if (tick) begin
            scl_q <= 1'b1;
            st    <= S_BHI;
          end
        end
        S_BHI: if (tick) begin
          scl_q <= 1'b0;
          if (bitn == 3'd7) begin
            st <= S_ALO;
          end else begin
            bitn  <= bitn + 3'd1;
            shreg <= {shreg[6:0], 1'b0};
            st    <= S_BLO;
          end
        end
        S_ALO: begin
          sda_q <= 1'b1;
          if (tick) begin
            scl_q <= 1'b1;
            st    <= S_AHI;
          end
        end
        S_AHI: if (tick) begin
          last_ptr <= data_ptr;
          data_ptr <= data_ptr + BUF_AW'(1);
          sent     <= sent_nx;
          if (ack_bad) begin
            aborted <= 1'b1;
            scl_q   <= 1'b0;
            st      <= S_SP0;
          end else if (left == CNT_W'(1)) begin
            cmd_idx <= cmd_idx + CMD_AW'(1);
            st      <= S_FETCH;
          end else begin
            left <= left - CNT_W'(1);
            st   <= S_LOAD;
          end
        end
        S_SP0: begin
          sda_q <= 1'b0;
          if (tick) begin
            scl_q <= 1'b1;
            st    <= S_SP1;
          end
        end
        S_SP1: if (tick) begin
          sda_q <= 1'b1;
          st    <= S_SP2;
        end
        S_SP2: if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_writer.sv
module i2c_cmd_writer #(
  parameter int CMD_AW = 2,
  parameter int BUF_AW = 4,
  parameter int HALF_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [HALF_W-1:0]           half_period,
  input  logic [i2cw_pkg::CNT_W-1:0]  tx_thresh,
  output logic [CMD_AW-1:0]           cmd_addr,
  input  logic [i2cw_pkg::CMD_W-1:0]  cmd_data,
  output logic [BUF_AW-1:0]           buf_addr,
  input  logic [7:0]                  buf_data,
  input  logic                        scl_in,
  input  logic                        sda_in,
  output logic                        scl_oe,
  output logic                        sda_oe,
  input  logic [i2cw_pkg::FL_N-1:0]   irq_clr,
  output logic [i2cw_pkg::FL_N-1:0]   irq_flags,
  output logic [BUF_AW-1:0]           last_addr
);
  logic              tick, run, arb_window, drive_bit, seq_idle;
  logic              ev_arb, ev_done, ev_ackerr, ev_thr;
  logic [BUF_AW-1:0] ev_addr;

  i2cw_tick #(.HALF_W(HALF_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .half_period(half_period), .tick(tick)
  );

  i2cw_arb u_arb (
    .window(arb_window), .drive_bit(drive_bit), .scl_in(scl_in),
    .sda_in(sda_in), .lost(ev_arb)
  );

  i2cw_seq #(.CMD_AW(CMD_AW), .BUF_AW(BUF_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .arb_lost(ev_arb),
    .scl_in(scl_in), .sda_in(sda_in), .tx_thresh(tx_thresh),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .buf_addr(buf_addr), .buf_data(buf_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .run(run),
    .arb_window(arb_window), .drive_bit(drive_bit), .idle(seq_idle),
    .ev_done(ev_done), .ev_ackerr(ev_ackerr), .ev_thr(ev_thr), .ev_addr(ev_addr)
  );

  i2cw_irq #(.BUF_AW(BUF_AW)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_ackerr(ev_ackerr),
    .ev_arb(ev_arb), .ev_thr(ev_thr), .ev_addr(ev_addr), .clr(irq_clr),
    .flags(irq_flags), .last_addr(last_addr)
  );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
  parameter int BUF_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              scl_in,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              seq_idle,
  input logic              arb_window,
  input logic              ev_arb,
  input logic              ev_done,
  input logic              ev_ackerr,
  input logic              ev_thr,
  input logic [3:0]        irq_clr,
  input logic [3:0]        irq_flags,
  input logic [BUF_AW-1:0] last_addr
);
  p_busy_bus_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && start && !scl_in) |=> seq_idle);

  p_sda_still_in_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_window && $past(arb_window)) |-> $stable(sda_oe));

  p_no_done_on_ackerr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ackerr |-> !ev_done);

  p_lines_free_after_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb |=> (!scl_oe && !sda_oe));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_thr || ev_done) |=> $stable(last_addr));

  p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> irq_flags[0]);

  p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_flags & $past(irq_flags & ~irq_clr)) == $past(irq_flags & ~irq_clr)));
endmodule

bind i2c_cmd_writer i2cw_checker #(.BUF_AW(BUF_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .scl_in(scl_in),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .seq_idle(seq_idle),
  .arb_window(arb_window), .ev_arb(ev_arb), .ev_done(ev_done),
  .ev_ackerr(ev_ackerr), .ev_thr(ev_thr), .irq_clr(irq_clr),
  .irq_flags(irq_flags), .last_addr(last_addr)
);

// File: tb/i2c_cmd_writer_tb.sv
module i2c_cmd_writer_tb_top;
  localparam int CMD_AW = 2;
  localparam int BUF_AW = 4;
  localparam int HALF_W = 8;
  localparam int HALF   = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, start;
  logic [HALF_W-1:0] half_period;
  logic [7:0]        tx_thresh;
  logic [CMD_AW-1:0] cmd_addr;
  logic [11:0]       cmd_data;
  logic [BUF_AW-1:0] buf_addr;
  logic [7:0]        buf_data;
  logic              scl_oe, sda_oe, scl_line, sda_line;
  logic [3:0]        irq_clr, irq_flags;
  logic [BUF_AW-1:0] last_addr;
  logic              ext_scl_low, slave_low, rival_low;

  logic [11:0] cmd_mem [0:3];
  logic [7:0]  buf_mem [0:15];
  assign cmd_data = cmd_mem[cmd_addr];
  assign buf_data = buf_mem[buf_addr];
  assign scl_line = !(scl_oe || ext_scl_low);
  assign sda_line = !(sda_oe || slave_low || rival_low);

  i2c_cmd_writer #(.CMD_AW(CMD_AW), .BUF_AW(BUF_AW), .HALF_W(HALF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .half_period(half_period),
    .tx_thresh(tx_thresh), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .buf_addr(buf_addr), .buf_data(buf_data), .scl_in(scl_line),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .irq_clr(irq_clr), .irq_flags(irq_flags), .last_addr(last_addr)
  );

  int vectors = 0;
  int fails   = 0;
  logic [7:0] exp_q [$];

  // slave / bus monitor state
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int   bitcnt = 0, byte_idx = 0, starts = 0, stops = 0, rise_no = 0;
  int   cyc = 0, t_rise = 0, t_fall0 = 0, hi_w0 = 0, lo_w0 = 0;
  int   nack_at = -1;
  bit   nack_all = 1'b0;
  logic [7:0] rx_sh = '0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic score(input logic [7:0] got);
    logic [7:0] e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R1 unexpected byte", got, 0);
    end else begin
      e = exp_q.pop_front();
      check(got == e, "R1 byte order", got, e);
    end
  endtask

  // monitor: decodes conditions, collects bytes, answers the acknowledge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      slave_low = 1'b0;
      bitcnt = 0;
    end else begin
      if (scl_line && prev_scl && (sda_line != prev_sda)) begin
        if (!sda_line) begin
          starts++; bitcnt = 0; byte_idx = 0; rise_no = 0;
        end else begin
          stops++;
        end
      end else if (scl_line && !prev_scl) begin
        rise_no++;
        if (rise_no == 1) t_rise = cyc;
        if (rise_no == 2) lo_w0 = cyc - t_fall0;
        if (bitcnt < 8) begin
          rx_sh = {rx_sh[6:0], sda_line};
          bitcnt++;
          if (bitcnt == 8) score(rx_sh);
        end else begin
          bitcnt = 0;
          byte_idx++;
        end
      end else if (!scl_line && prev_scl) begin
        if (rise_no == 1) begin
          hi_w0 = cyc - t_rise;
          t_fall0 = cyc;
        end
        slave_low = (bitcnt == 8) && !(nack_all || (byte_idx == nack_at));
      end
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary_and_end();
  end

  // driver: loads command list and buffer, pushes expected bytes
  task automatic prep_txn(input logic [6:0] tgt, input int n, input bit chk,
                          input bit expv, input int push_last);
    buf_mem[0] = {tgt, 1'b0};
    for (int i = 1; i < 16; i++) buf_mem[i] = 8'(i * 37 + 5);
    cmd_mem[0] = {8'd0, 1'b0, 1'b0, 2'b00};
    cmd_mem[1] = {8'(n + 1), expv, chk, 2'b01};
    cmd_mem[2] = {8'd0, 1'b0, 1'b0, 2'b10};
    cmd_mem[3] = {8'd0, 1'b0, 1'b0, 2'b10};
    exp_q.delete();
    for (int i = 0; i <= push_last; i++) exp_q.push_back(buf_mem[i]);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic clr_flags(input logic [3:0] m);
    @(negedge clk) irq_clr = m;
    @(negedge clk) irq_clr = '0;
  endtask

  task automatic wait_flag(input int b, input string tag);
    int t = 0;
    while (!irq_flags[b] && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(irq_flags[b], tag, irq_flags, 1 << b);
  endtask

  initial begin
    int s0, p0;
    rst_n = 1'b0; start = 1'b0; irq_clr = '0; half_period = HALF_W'(HALF);
    tx_thresh = 8'd255; ext_scl_low = 1'b0; rival_low = 1'b0;
    for (int i = 0; i < 4; i++) cmd_mem[i] = '0;
    for (int i = 0; i < 16; i++) buf_mem[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(!scl_oe && !sda_oe, "R11 lines released", {scl_oe, sda_oe}, 0);
    check(irq_flags == 0, "R11 flags clear", irq_flags, 0);
    check(last_addr == 0, "R11 last_addr", last_addr, 0);

    // R2: bus held busy
    prep_txn(7'h2A, 1, 1'b1, 1'b0, -1);
    ext_scl_low = 1'b1;
    pulse_start();
    repeat (30) @(negedge clk);
    check(!scl_oe && !sda_oe && irq_flags == 0, "R2 start while SCL low", {irq_flags, scl_oe, sda_oe}, 0);
    ext_scl_low = 1'b0;
    repeat (30) @(negedge clk);
    check(!scl_oe && !sda_oe && irq_flags == 0, "R2 request not remembered", {irq_flags, scl_oe, sda_oe}, 0);

    // R1 R3 R7 R8 R9: normal six-byte write, threshold 2
    s0 = starts; p0 = stops;
    tx_thresh = 8'd2;
    prep_txn(7'h2A, 5, 1'b1, 1'b0, 5);
    pulse_start();
    wait_flag(3, "R7 threshold flag");
    check(last_addr == 2, "R7 index at threshold", last_addr, 2);
    wait_flag(0, "R8 done flag");
    check(last_addr == 5, "R8 index at done", last_addr, 5);
    check(exp_q.size() == 0, "R1 all bytes seen", exp_q.size(), 0);
    check(starts - s0 == 1 && stops - p0 == 1, "R3 one start one stop", (starts - s0) * 16 + (stops - p0), 17);
    check(hi_w0 == HALF, "R9 high phase", hi_w0, HALF);
    check(lo_w0 == HALF, "R9 low phase", lo_w0, HALF);
    check(irq_flags[2:1] == 0, "R4 R6 no error flags", irq_flags, 9);

    // R10: write-one-to-clear
    clr_flags(4'b0010);
    check(irq_flags == 4'b1001, "R10 other flags kept", irq_flags, 9);
    clr_flags(4'b1001);
    check(irq_flags == 0, "R10 cleared", irq_flags, 0);

    // R4: NACK on third byte with checking on
    tx_thresh = 8'd255;
    s0 = starts; p0 = stops;
    nack_at = 2;
    prep_txn(7'h51, 3, 1'b1, 1'b0, 2);
    pulse_start();
    wait_flag(1, "R4 ack error flag");
    repeat (10 * HALF) @(negedge clk);
    check(stops - p0 == 1, "R4 stop after error", stops - p0, 1);
    check(irq_flags[0] == 1'b0, "R4 no done", irq_flags, 2);
    check(exp_q.size() == 0, "R4 transfer stopped at nacked byte", exp_q.size(), 0);
    check(!scl_oe && !sda_oe, "R4 lines released", {scl_oe, sda_oe}, 0);
    check(last_addr == 5, "R7 last_addr untouched", last_addr, 5);
    clr_flags(4'hF);

    // R5: same NACK, checking off
    prep_txn(7'h51, 3, 1'b0, 1'b0, 3);
    pulse_start();
    wait_flag(0, "R5 done despite nack");
    check(irq_flags[1] == 1'b0, "R5 no ack error", irq_flags, 1);
    check(exp_q.size() == 0, "R5 all bytes", exp_q.size(), 0);
    check(last_addr == 3, "R8 index at done", last_addr, 3);
    clr_flags(4'hF);
    nack_at = -1;

    // R4: expected level 1, slave never acknowledges
    nack_all = 1'b1;
    prep_txn(7'h33, 2, 1'b1, 1'b1, 2);
    pulse_start();
    wait_flag(0, "R4 expected-high ack");
    check(irq_flags[1] == 1'b0, "R4 matching high ack", irq_flags, 1);
    nack_all = 1'b0;
    clr_flags(4'hF);

    // R6: competing master on the second byte
    s0 = starts; p0 = stops;
    prep_txn(7'h12, 2, 1'b1, 1'b0, 0);
    buf_mem[1] = 8'hA5;
    pulse_start();
    begin
      int t = 0;
      while (!(byte_idx == 1 && !scl_line) && t < 5000) begin
        @(negedge clk);
        t++;
      end
    end
    rival_low = 1'b1;
    wait_flag(2, "R6 arbitration flag");
    @(negedge clk);
    check(!scl_oe && !sda_oe, "R6 lines released", {scl_oe, sda_oe}, 0);
    check(stops - p0 == 0, "R6 no stop driven", stops - p0, 0);
    check(irq_flags[0] == 1'b0, "R6 no done", irq_flags, 4);
    rival_low = 1'b0;
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R1 address byte before loss", exp_q.size(), 0);

    summary_and_end();
  end
endmodule